// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM of 256K words by 16 bits. The host hands over one word-sized read or write at a time, with an 18-bit word address, 16-bit write data and a two-bit byte-lane mask. The controller turns each request into a strobe sequence on the memory pins: chip select, output enable, write strobe and two byte-lane enables, all active low. It also drives the address bus and controls a 16-bit data driver whose tri-state enable is a separate pin.

All memory-side outputs come straight from flip-flops. Each minimum timing of the memory is turned into a whole number of clock cycles at elaboration time. The conversion divides the time by the clock-period parameter, rounds up and never goes below one cycle. The read window, the write strobe width, the data setup and the write cycle length are each derived on their own. `ready` is high whenever the controller can take a request. It falls for the duration of an access and rises again when the access is complete, with read data valid from that cycle on.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `sram_ce_n`, `sram_oe_n`, `sram_we_n` and both bits of `sram_be_n` are 1, `sram_dq_oe` is 0, `ready` is 1 and `rd_data` is 0.
- R2: A request is taken at a rising edge where `req_valid` and `ready` are both 1. For a read (`req_write`=0), the following cycle shows `sram_ce_n`=0, `sram_oe_n`=0 and `sram_we_n`=1, with `req_addr` on `sram_addr`. `sram_addr` stays unchanged while `sram_ce_n` stays low. `sram_be_n[0]` = ~`req_be[0]` gates bits 7:0, and `sram_be_n[1]` = ~`req_be[1]` gates bits 15:8.
- R3: A read holds its strobes low for RD = max(ceil(55 ns/T), ceil(30 ns/T), ceil(55 ns/T)) cycles, where T = `CLK_PERIOD_NS` (3 cycles at T = 20). On the edge that ends this window, `sram_dq_in` is captured into `rd_data` and `ready` returns to 1. `ready` is therefore low for exactly RD cycles.
- R4: On a read, a byte lane whose `req_be` bit is 0 reads as 0x00 in `rd_data`, whatever is on the bus.
- R5: `sram_dq_oe` is 1 only while `sram_we_n` is 0. The data driver is never on while the memory can be driving the bus.
- R6: A write (`req_write`=1) gives `sram_ce_n`=0, `sram_we_n`=0 and `sram_oe_n`=1 from its first cycle. In that same cycle `sram_dq_oe`=1 and `sram_dq_out`=`req_wdata`. `sram_we_n` stays low for WP = max(ceil(45 ns/T), ceil(25 ns/T)) cycles (3 at T = 20).
- R7: A write changes only the byte lanes whose `req_be` bit is 1. The other lane of the addressed word keeps its old contents.
- R8: After the write strobe rises, all strobes stay high and `sram_dq_oe` stays 0 for REC = max(ceil(55 ns/T) − WP, 1) cycles, and only then does `ready` return. `ready` is low for WP+REC cycles (4 at T = 20). A read issued right after a write therefore sees at least one quiet cycle before its chip select falls.
- R9: A request with `req_be`=2'b00 completes at once. `sram_ce_n` never falls, `ready` stays 1, no memory word changes and `rd_data` keeps its value.
- R10: `req_valid` is ignored while `ready` is 0. A request raised and withdrawn during a busy access is neither performed nor queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | Controller free; rises when an access completes |
| rd_data | output | 16 | Captured read data |
| sram_ce_n | output | 1 | Memory chip select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write strobe, active low |
| sram_be_n | output | 2 | Byte-lane enables, active low, bit 0 lower |
| sram_addr | output | 18 | Memory address bus |
| sram_dq_out | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | Enable of the data driver |
| sram_dq_in | input | 16 | Data from the memory |

## Verification
A counter that is off by one, or a wrong state, shows up at the pins within one access. A strobe window is one cycle short or long, or `ready` returns on the wrong cycle. The bench's memory model drives garbage until the read window is complete, so an early capture gives wrong `rd_data` on that same read. A state that confuses the lanes or the direction shows up on the next readback, either as corrupted neighbouring bytes or as the driver being on during a read, which is counted on every cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WPULSE = 2'd2,
        ST_WREC   = 2'd3
    } ctl_state_e;

    // time in ns to whole cycles, rounded up, at least one
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/sram_ctrl_rdcap.sv
module sram_ctrl_rdcap #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LANE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       capture,
    input  logic [DATA_W/LANE_W-1:0]   lane_en,
    input  logic [DATA_W-1:0]          bus_in,
    output logic [DATA_W-1:0]          rd_data
);
    localparam int unsigned LANES = DATA_W / LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (capture)
                lane_d = lane_en[i] ? bus_in[i*LANE_W +: LANE_W] : '0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) lane_q <= '0;
            else        lane_q <= lane_d;
        end

        assign rd_data[i*LANE_W +: LANE_W] = lane_q;
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 18,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned LANE_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_ADDR_ACC_NS = 55,
    parameter int unsigned T_OE_ACC_NS   = 30,
    parameter int unsigned T_RD_CYC_NS   = 55,
    parameter int unsigned T_WE_PULSE_NS = 45,
    parameter int unsigned T_D_SETUP_NS  = 25,
    parameter int unsigned T_WR_CYC_NS   = 55
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic [DATA_W/LANE_W-1:0]  req_be,
    output logic                      ready,
    output logic [DATA_W-1:0]         rd_data,
    output logic                      sram_ce_n,
    output logic                      sram_oe_n,
    output logic                      sram_we_n,
    output logic [DATA_W/LANE_W-1:0]  sram_be_n,
    output logic [ADDR_W-1:0]         sram_addr,
    output logic [DATA_W-1:0]         sram_dq_out,
    output logic                      sram_dq_oe,
    input  logic [DATA_W-1:0]         sram_dq_in
);
    localparam int unsigned LANES   = DATA_W / LANE_W;
    localparam int unsigned RD_CYC  = max2(max2(ns_to_cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                                ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS)),
                                           ns_to_cyc(T_RD_CYC_NS, CLK_PERIOD_NS));
    localparam int unsigned WP_CYC  = max2(ns_to_cyc(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_D_SETUP_NS, CLK_PERIOD_NS));
    localparam int unsigned WC_CYC  = ns_to_cyc(T_WR_CYC_NS, CLK_PERIOD_NS);
    localparam int unsigned REC_CYC = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC) : 1;
    localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WP_CYC), REC_CYC);
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctl_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic                ce_n;
        logic                oe_n;
        logic                we_n;
        logic [LANES-1:0]    be_n;
        logic                dq_oe;
        logic [DATA_W-1:0]   dq_out;
        logic                ready;
        logic [LANES-1:0]    lanes;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_last;
    logic          cap;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid && r_q.ready && (req_be != '0)) begin
                    r_d.addr  = req_addr;
                    r_d.ce_n  = 1'b0;
                    r_d.be_n  = ~req_be;
                    r_d.lanes = req_be;
                    r_d.ready = 1'b0;
                    tmr_load  = 1'b1;
                    if (req_write) begin
                        r_d.we_n   = 1'b0;
                        r_d.oe_n   = 1'b1;
                        r_d.dq_oe  = 1'b1;
                        r_d.dq_out = req_wdata;
                        r_d.st     = ST_WPULSE;
                        tmr_val    = CW'(WP_CYC);
                    end else begin
                        r_d.oe_n   = 1'b0;
                        r_d.we_n   = 1'b1;
                        r_d.st     = ST_READ;
                        tmr_val    = CW'(RD_CYC);
                    end
                end
            end
            ST_READ: begin
                if (tmr_last) begin
                    cap       = 1'b1;
                    r_d.ce_n  = 1'b1;
                    r_d.oe_n  = 1'b1;
                    r_d.be_n  = '1;
                    r_d.ready = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            ST_WPULSE: begin
                if (tmr_last) begin
                    r_d.ce_n  = 1'b1;
                    r_d.we_n  = 1'b1;
                    r_d.be_n  = '1;
                    r_d.dq_oe = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(REC_CYC);
                    r_d.st    = ST_WREC;
                end
            end
            ST_WREC: begin
                if (tmr_last) begin
                    r_d.ready = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.addr   <= '0;
            r_q.ce_n   <= 1'b1;
            r_q.oe_n   <= 1'b1;
            r_q.we_n   <= 1'b1;
            r_q.be_n   <= '1;
            r_q.dq_oe  <= 1'b0;
            r_q.dq_out <= '0;
            r_q.ready  <= 1'b1;
            r_q.lanes  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    sram_ctrl_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sram_ctrl_rdcap #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap),
        .lane_en (r_q.lanes),
        .bus_in  (sram_dq_in),
        .rd_data (rd_data)
    );

    assign ready       = r_q.ready;
    assign sram_ce_n   = r_q.ce_n;
    assign sram_oe_n   = r_q.oe_n;
    assign sram_we_n   = r_q.we_n;
    assign sram_be_n   = r_q.be_n;
    assign sram_addr   = r_q.addr;
    assign sram_dq_out = r_q.dq_out;
    assign sram_dq_oe  = r_q.dq_oe;

    // run-length counters used only by the checks below
    logic [CW:0] we_run_q, oe_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run_q <= '0;
            oe_run_q <= '0;
        end else begin
            we_run_q <= sram_we_n ? '0 : we_run_q + 1'b1;
            oe_run_q <= sram_oe_n ? '0 : oe_run_q + 1'b1;
        end
    end

    assert_oe_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n));

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    assert_read_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (oe_run_q >= (CW+1)'(RD_CYC)));

    assert_no_read_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> !sram_we_n);

    assert_we_pulse_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_run_q >= (CW+1)'(WP_CYC)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sram_ce_n && sram_we_n && !sram_dq_oe));

    assert_zero_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ready && (req_be == '0)) |=> (ready && sram_ce_n));

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !sram_ce_n) |=> $stable(sram_addr) || sram_ce_n);
endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;
    localparam int RD  = 3;  // ceil(55/20)
    localparam int WP  = 3;  // ceil(45/20)
    localparam int REC = 1;  // max(3-3,1)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        ready;
    logic [15:0] rd_data;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [1:0]  sram_be_n;
    logic [17:0] sram_addr;
    logic [15:0] sram_dq_out, sram_dq_in;

    int checks = 0, fails = 0, cyc = 0;

    always #10 clk = ~clk;

    sram_ctrl #(.CLK_PERIOD_NS(20)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .ready(ready), .rd_data(rd_data),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_be_n(sram_be_n), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // device model, small window of the address space
    logic [15:0] mem [64];
    logic [15:0] shadow [64];
    int rd_cnt = 0, ce_run = 0, last_ce_run = 0, we_run = 0, last_we_run = 0;
    int ce_falls = 0, contention = 0, quiet = 0, turn_gap = -1;
    logic prev_ce = 1'b1, after_wr = 1'b0;
    logic [17:0] addr_at_fall = '0;

    logic [15:0] word;
    assign word = mem[sram_addr[5:0]];
    assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n && rd_cnt >= RD) ?
        {sram_be_n[1] ? 8'hEE : word[15:8], sram_be_n[0] ? 8'hEE : word[7:0]} : 16'hDEAD;

    always @(negedge clk) begin
        if (!sram_ce_n && !sram_we_n) begin
            if (!sram_be_n[0]) mem[sram_addr[5:0]][7:0]  = sram_dq_oe ? sram_dq_out[7:0]  : 8'hBA;
            if (!sram_be_n[1]) mem[sram_addr[5:0]][15:8] = sram_dq_oe ? sram_dq_out[15:8] : 8'hBA;
        end
        if (!sram_ce_n && !sram_oe_n && sram_we_n) rd_cnt = rd_cnt + 1; else rd_cnt = 0;
        if (!sram_ce_n) ce_run = ce_run + 1;
        else begin if (ce_run != 0) last_ce_run = ce_run; ce_run = 0; end
        if (!sram_we_n) we_run = we_run + 1;
        else begin if (we_run != 0) last_we_run = we_run; we_run = 0; end
        if (sram_dq_oe && !sram_ce_n && !sram_oe_n && sram_we_n) contention = contention + 1;
        if (!sram_ce_n && prev_ce) begin
            ce_falls = ce_falls + 1;
            addr_at_fall = sram_addr;
            if (!sram_oe_n && after_wr) begin turn_gap = quiet; after_wr = 1'b0; end
        end
        if (!sram_we_n) begin after_wr = 1'b1; quiet = 0; end
        else if (sram_ce_n && sram_oe_n && !sram_dq_oe) quiet = quiet + 1;
        prev_ce = sram_ce_n;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic n1_oe_n, n1_we_n, n1_dq_oe;
    logic [15:0] n1_dq_out;

    task automatic do_req(input logic w, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] be, output int busy);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        n1_oe_n = sram_oe_n; n1_we_n = sram_we_n; n1_dq_oe = sram_dq_oe; n1_dq_out = sram_dq_out;
        busy = 0;
        while (!ready) begin busy++; @(negedge clk); end
        if (w) begin
            if (be[0]) shadow[a[5:0]][7:0]  = d[7:0];
            if (be[1]) shadow[a[5:0]][15:8] = d[15:8];
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 strobes", {27'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_be_n}, 32'h1F);
        chk("R1 dq_oe", sram_dq_oe, 0);
        chk("R1 ready", ready, 1);
        chk("R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {28'd0, sram_ce_n, sram_we_n, ready, sram_dq_oe}, 32'hE);
    endtask

    task automatic t_full;
        int b;
        do_req(1, 18'h00005, 16'h1234, 2'b11, b);
        chk("R6 write first cycle oe_n/we_n/dq_oe", {29'd0, n1_oe_n, n1_we_n, n1_dq_oe}, 32'h5);
        chk("R6 write data on bus", n1_dq_out, 16'h1234);
        chk("R6 we low cycles", last_we_run, WP);
        chk("R8 write busy cycles", b, WP + REC);
        do_req(0, 18'h00005, 16'h0, 2'b11, b);
        chk("R3 read busy cycles", b, RD);
        chk("R3 ce low cycles", last_ce_run, RD);
        chk("R3 read data", rd_data, 16'h1234);
        chk("R5 no contention", contention, 0);
    endtask

    task automatic t_high_addr;
        int b;
        do_req(1, 18'h3FFC7, 16'hA5C3, 2'b11, b);
        chk("R2 write address at ce fall", addr_at_fall, 18'h3FFC7);
        do_req(0, 18'h3FFC7, 16'h0, 2'b11, b);
        chk("R2 read address at ce fall", addr_at_fall, 18'h3FFC7);
        chk("R2 read data", rd_data, 16'hA5C3);
    endtask

    task automatic t_lanes;
        int b;
        do_req(1, 18'h00005, 16'hFF11, 2'b01, b);
        do_req(0, 18'h00005, 16'h0, 2'b11, b);
        chk("R7 lower only write", rd_data, 16'h1211);
        do_req(1, 18'h00005, 16'h77FF, 2'b10, b);
        do_req(0, 18'h00005, 16'h0, 2'b11, b);
        chk("R7 upper only write", rd_data, 16'h7711);
    endtask

    task automatic t_read_lanes;
        int b;
        do_req(0, 18'h00005, 16'h0, 2'b01, b);
        chk("R4 lower lane read", rd_data, 16'h0011);
        do_req(0, 18'h00005, 16'h0, 2'b10, b);
        chk("R4 upper lane read", rd_data, 16'h7700);
    endtask

    task automatic t_zero_mask;
        int b, f0;
        f0 = ce_falls;
        do_req(1, 18'h00005, 16'h0000, 2'b00, b);
        chk("R9 zero mask write busy", b, 0);
        do_req(0, 18'h00005, 16'h0000, 2'b00, b);
        chk("R9 zero mask read keeps rd_data", rd_data, 16'h7700);
        chk("R9 no chip select", ce_falls - f0, 0);
        do_req(0, 18'h00005, 16'h0, 2'b11, b);
        chk("R9 memory unchanged", rd_data, 16'h7711);
    endtask

    task automatic t_turnaround;
        int b;
        do_req(1, 18'h00009, 16'h5A5A, 2'b11, b);
        do_req(0, 18'h00009, 16'h0, 2'b11, b);
        chk("R8 quiet cycle before read", (turn_gap >= 1) ? 1 : 0, 1);
        chk("R8 read after write data", rd_data, 16'h5A5A);
        chk("R5 no contention", contention, 0);
    endtask

    task automatic t_busy_ignore;
        int b;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00005; req_be = 2'b11;
        @(negedge clk);
        req_write = 1'b1; req_addr = 18'h0000C; req_wdata = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0;
        while (!ready) @(negedge clk);
        chk("R10 first read completes", rd_data, 16'h7711);
        repeat (3) @(negedge clk);
        do_req(0, 18'h0000C, 16'h0, 2'b11, b);
        chk("R10 busy request dropped", rd_data, shadow[12]);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin mem[i] = 16'h0; shadow[i] = 16'h0; end
        t_reset;
        t_full;
        t_high_addr;
        t_lanes;
        t_read_lanes;
        t_zero_mask;
        t_turnaround;
        t_busy_ignore;
        chk("R5 no contention overall", contention, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule